// File: doc/BRIEF.md
# Integer Status Flag Unit

This block sits beside a 64-bit integer ALU and turns one completed operation into the architectural status flags. It takes the operands as the ALU saw them, the result, and a handful of per-operation controls. From these it forms the unsigned carry at 64 and 32 bits, the signed overflow at 64 and 32 bits, the sticky summary overflow, and the 4-bit compare field of condition field zero. The ALU itself is outside the block.

The first operand may be bitwise inverted before any flag is formed, for subtract-style operations. A register operand and an immediate can each be marked present. Some operations produce a carry or an overflow of their own: shifts supply the carry, and divides supply the overflow. Those supplied values replace the derived ones.

Separate enables choose which flag groups an operation may write. Every selected flag is loaded on one update strobe.

Top module: `int_status_flags`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every flag output is 0 after that edge.
- R2: When `upd_i` is low at a clock edge, no flag output changes at that edge, whatever the other inputs do.
- R3: When `inv_a_i` is 1, operand A is replaced by its bitwise inverse before every flag computation: carry, overflow and the operand-B-free cases alike.
- R4: On an update with `ca_en_i`=1, `ca_o` becomes 1 when any present operand is unsigned-greater than the result. Operand A is always present; B is present when `opb_vld_i`=1 and the immediate when `imm_vld_i`=1. With `ca_en_i`=0, neither `ca_o` nor `ca32_o` changes.
- R5: On an update with `ca_en_i`=1 and `add_op_i`=1, `ca32_o` becomes result bit 32 XOR A bit 32 XOR second-operand bit 32. The second operand is B when present, else the immediate when valid, else zero.
- R6: On an update with `ca_en_i`=1 and `add_op_i`=0, `ca32_o` becomes 1 when the low 32 bits of any present operand are unsigned-greater than the low 32 bits of the result.
- R7: When `ca_own_vld_i` (or `ca32_own_vld_i`) is 1 on an update with `ca_en_i`=1, the carry (or 32-bit carry) is loaded from `ca_own_i` (or `ca32_own_i`) instead of the derived value.
- R8: Overflow flags are written only on an update with both `oe_en_i` and `oe_vld_i` at 1, and only when either a second operand is present or `div_op_i`=1. `ov_o` is 1 when A and the second operand share bit 63 and the result's bit 63 differs from A's. `ov32_o` applies the same rule to bit 31.
- R9: When an overflow write has `div_op_i`=1, both `ov_o` and `ov32_o` take the value of `div_ov_i`.
- R10: An overflow write sets `so_o` to its old value OR the new `ov_o`. No input clears `so_o` except reset.
- R11: On an update with `rc_i`=1, `cr0_o` becomes {negative, positive, zero, SO}, with bit 3 meaning negative down to bit 0 meaning SO. The result is taken as signed 64-bit, and SO is the value after this same update. With `rc_i`=0, `cr0_o` does not change.
- R12: All flags selected by one update change together at the first clock edge where `upd_i` is high, and are visible right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe, loads the selected flags |
| inv_a_i | input | 1 | Invert operand A before flag computation |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| opb_vld_i | input | 1 | Operand B is present |
| imm_i | input | 64 | Immediate operand |
| imm_vld_i | input | 1 | Immediate is present |
| res_i | input | 64 | ALU result |
| add_op_i | input | 1 | Operation is add-type (selects 32-bit carry rule) |
| ca_en_i | input | 1 | Carry flags may be written |
| ca_own_vld_i | input | 1 | Operation supplies its own carry |
| ca_own_i | input | 1 | Supplied carry value |
| ca32_own_vld_i | input | 1 | Operation supplies its own 32-bit carry |
| ca32_own_i | input | 1 | Supplied 32-bit carry value |
| oe_en_i | input | 1 | Overflow enable |
| oe_vld_i | input | 1 | Overflow enable is valid |
| div_op_i | input | 1 | Divide-type operation supplies overflow |
| div_ov_i | input | 1 | Divide overflow value |
| rc_i | input | 1 | Record compare field zero |
| ca_o | output | 1 | Carry |
| ca32_o | output | 1 | 32-bit carry |
| ov_o | output | 1 | Overflow |
| ov32_o | output | 1 | 32-bit overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr0_o | output | 4 | Compare field {neg, pos, zero, SO} |

## Verification
The hardest case to reach is one update that writes overflow and the compare field together. SO must first become set by this very operation, and that new SO must already appear in `cr0_o[0]`. The stimulus builds a signed overflow whose result is negative, with `rc_i` set. It then follows with non-overflowing operations to show that SO holds and keeps appearing in the compare field. Single-operand operations without a divide are driven with both overflow enables high, to show the overflow flags hold. A randomized stream then mixes every control combination against the bench's own flag model.

// File: rtl/flag_pkg.sv
// Package: shared types for the integer status flag unit.
// Assumes: flags are single bits, compare field is four bits.
package flag_pkg;

    // Registered architectural flag state.
    typedef struct packed {
        logic       ca;
        logic       ca32;
        logic       ov;
        logic       ov32;
        logic       so;
        logic [3:0] cr0;
    } flag_state_t;

    // Position of each compare-field bit.
    localparam int unsigned CR_NEG  = 3;
    localparam int unsigned CR_POS  = 2;
    localparam int unsigned CR_ZERO = 1;
    localparam int unsigned CR_SO   = 0;

endpackage

// File: rtl/carry_derive.sv
// Module: carry_derive
// Derives the full-width and half-width carry from a set of operand slots
// and the result. Slot 0 is operand A and is always taken; the others are
// gated by their valid bits.
// Assumes: HALF_W < DATA_W, second operand already chosen by the caller.
module carry_derive #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned HALF_W = 32,
    parameter int unsigned NOPS   = 3
) (
    input  logic [NOPS-1:0][DATA_W-1:0] ops_i,
    input  logic [NOPS-1:0]             ops_vld_i,
    input  logic [DATA_W-1:0]           sec_i,
    input  logic [DATA_W-1:0]           res_i,
    input  logic                        add_op_i,
    output logic                        ca_o,
    output logic                        ca32_o
);
    logic [NOPS-1:0] gt_full;
    logic [NOPS-1:0] gt_half;

    // One pair of unsigned comparators per operand slot.
    for (genvar s = 0; s < NOPS; s++) begin : g_slot
        assign gt_full[s] = ops_vld_i[s] && (ops_i[s] > res_i);
        assign gt_half[s] = ops_vld_i[s] &&
                            (ops_i[s][HALF_W-1:0] > res_i[HALF_W-1:0]);
    end

    logic ca32_add;
    // Carry into bit HALF_W recovered from the three bits at that position.
    assign ca32_add = res_i[HALF_W] ^ ops_i[0][HALF_W] ^ sec_i[HALF_W];

    // Select the carry rule for this operation type.
    always_comb begin
        ca_o   = |gt_full;
        ca32_o = add_op_i ? ca32_add : (|gt_half);
    end
endmodule

// File: rtl/ovf_derive.sv
// Module: ovf_derive
// Signed overflow at full width and at half width from the two leading
// operands and the result, one lane per width.
// Assumes: both operands are already in their final (possibly inverted) form.
module ovf_derive #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned HALF_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_i,
    output logic              ov_o,
    output logic              ov32_o
);
    localparam int unsigned NLANE = 2;
    logic [NLANE-1:0] lane_ov;

    // Lane 0 checks the top sign bit, lane 1 the half-word sign bit.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        localparam int unsigned SB = (l == 0) ? DATA_W - 1 : HALF_W - 1;
        assign lane_ov[l] = (a_i[SB] == b_i[SB]) && (res_i[SB] != a_i[SB]);
    end

    // Route lanes to named outputs.
    always_comb begin
        ov_o   = lane_ov[0];
        ov32_o = lane_ov[1];
    end
endmodule

// File: rtl/cmp_field.sv
// Module: cmp_field
// Builds the four-bit compare field from a signed result and the summary
// overflow bit that accompanies it.
// Assumes: result is two's complement of DATA_W bits.
module cmp_field
    import flag_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              so_i,
    output logic [3:0]        cr_o
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (res_i == '0);
    assign is_neg  = res_i[DATA_W-1];

    // Exactly one of negative, positive or zero is set.
    always_comb begin
        cr_o          = '0;
        cr_o[CR_NEG]  = is_neg;
        cr_o[CR_POS]  = !is_neg && !is_zero;
        cr_o[CR_ZERO] = is_zero;
        cr_o[CR_SO]   = so_i;
    end
endmodule

// File: rtl/int_status_flags.sv
// Module: int_status_flags (top)
// Computes carry, overflow, summary overflow and compare-field flags after
// an integer operation and holds them in a register that loads on upd_i.
// Assumes: inputs are stable at the clock edge where upd_i is high; the
// operation's own carry and divide overflow are valid with their flags.
module int_status_flags
    import flag_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              inv_a_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              opb_vld_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              imm_vld_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              add_op_i,
    input  logic              ca_en_i,
    input  logic              ca_own_vld_i,
    input  logic              ca_own_i,
    input  logic              ca32_own_vld_i,
    input  logic              ca32_own_i,
    input  logic              oe_en_i,
    input  logic              oe_vld_i,
    input  logic              div_op_i,
    input  logic              div_ov_i,
    input  logic              rc_i,
    output logic              ca_o,
    output logic              ca32_o,
    output logic              ov_o,
    output logic              ov32_o,
    output logic              so_o,
    output logic [3:0]        cr0_o
);
    localparam int unsigned NOPS = 3;   // A, B, immediate

    flag_state_t st_q;

    // ---------------- operand preparation ----------------
    logic [DATA_W-1:0]           a_eff;
    logic [DATA_W-1:0]           sec_op;
    logic                        has_sec;
    logic [NOPS-1:0][DATA_W-1:0] ops;
    logic [NOPS-1:0]             ops_vld;

    // Apply inversion and pick the second operand (B before immediate).
    always_comb begin
        a_eff   = inv_a_i ? ~opa_i : opa_i;
        has_sec = opb_vld_i || imm_vld_i;
        if (opb_vld_i)      sec_op = opb_i;
        else if (imm_vld_i) sec_op = imm_i;
        else                sec_op = '0;
        ops     = {imm_i, opb_i, a_eff};
        ops_vld = {imm_vld_i, opb_vld_i, 1'b1};
    end

    // ---------------- derived flags ----------------
    logic ca_d, ca32_d, ov_d, ov32_d;

    carry_derive #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W),
        .NOPS   (NOPS)
    ) u_carry (
        .ops_i     (ops),
        .ops_vld_i (ops_vld),
        .sec_i     (sec_op),
        .res_i     (res_i),
        .add_op_i  (add_op_i),
        .ca_o      (ca_d),
        .ca32_o    (ca32_d)
    );

    ovf_derive #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) u_ovf (
        .a_i    (a_eff),
        .b_i    (sec_op),
        .res_i  (res_i),
        .ov_o   (ov_d),
        .ov32_o (ov32_d)
    );

    // ---------------- next-state selection ----------------
    logic ov_wr;
    logic ov_new, ov32_new, so_new;
    logic ca_new, ca32_new;

    // Overflow group: gate on both enables, divide value wins over derived.
    always_comb begin
        ov_wr    = oe_en_i && oe_vld_i && (div_op_i || has_sec);
        ov_new   = st_q.ov;
        ov32_new = st_q.ov32;
        so_new   = st_q.so;
        if (ov_wr) begin
            ov_new   = div_op_i ? div_ov_i : ov_d;
            ov32_new = div_op_i ? div_ov_i : ov32_d;
            so_new   = st_q.so | ov_new;
        end
    end

    // Carry group: operation-supplied values take precedence.
    always_comb begin
        ca_new   = st_q.ca;
        ca32_new = st_q.ca32;
        if (ca_en_i) begin
            ca_new   = ca_own_vld_i   ? ca_own_i   : ca_d;
            ca32_new = ca32_own_vld_i ? ca32_own_i : ca32_d;
        end
    end

    logic [3:0] cr_d;

    cmp_field #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .res_i (res_i),
        .so_i  (so_new),
        .cr_o  (cr_d)
    );

    // ---------------- flag register ----------------
    // Load all selected flags together on the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (upd_i) begin
            st_q.ca   <= ca_new;
            st_q.ca32 <= ca32_new;
            st_q.ov   <= ov_new;
            st_q.ov32 <= ov32_new;
            st_q.so   <= so_new;
            if (rc_i) begin
                st_q.cr0 <= cr_d;
            end
        end
    end

    // Drive outputs from the register.
    always_comb begin
        ca_o   = st_q.ca;
        ca32_o = st_q.ca32;
        ov_o   = st_q.ov;
        ov32_o = st_q.ov32;
        so_o   = st_q.so;
        cr0_o  = st_q.cr0;
    end
endmodule

// File: rtl/int_status_flags_chk.sv
// Module: int_status_flags_chk
// Port-level properties of the status flag unit, bound into the top.
module int_status_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_i,
    input logic       ca_en_i,
    input logic       oe_en_i,
    input logic       oe_vld_i,
    input logic       div_op_i,
    input logic       div_ov_i,
    input logic       rc_i,
    input logic       ca_o,
    input logic       ca32_o,
    input logic       ov_o,
    input logic       ov32_o,
    input logic       so_o,
    input logic [3:0] cr0_o
);
    // R1: synchronous reset clears every flag
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ({ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o} == 9'd0));

    // R2: no strobe, no change
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable({ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o}));

    // R4: carry group untouched without its enable
    a_r4_carry_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !ca_en_i) |=> $stable({ca_o, ca32_o}));

    // R8: overflow group untouched without both enables
    a_r8_ovf_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !(oe_en_i && oe_vld_i)) |=> $stable({ov_o, ov32_o, so_o}));

    // R9: divide overflow drives both widths and the summary bit
    a_r9_div_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && oe_en_i && oe_vld_i && div_op_i && div_ov_i)
            |=> (ov_o && ov32_o && so_o));

    // R10: summary overflow is sticky
    a_r10_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        so_o |=> so_o);

    // R11: compare field untouched without record
    a_r11_cr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !rc_i) |=> $stable(cr0_o));

    // R11: recorded compare field carries the updated summary bit
    a_r11_cr_so: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && rc_i) |=> (cr0_o[0] == so_o));

    // R11: exactly one sign class recorded
    a_r11_cr_class: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && rc_i) |=> ($countones(cr0_o[3:1]) == 1));
endmodule

bind int_status_flags int_status_flags_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (upd_i),
    .ca_en_i  (ca_en_i),
    .oe_en_i  (oe_en_i),
    .oe_vld_i (oe_vld_i),
    .div_op_i (div_op_i),
    .div_ov_i (div_ov_i),
    .rc_i     (rc_i),
    .ca_o     (ca_o),
    .ca32_o   (ca32_o),
    .ov_o     (ov_o),
    .ov32_o   (ov32_o),
    .so_o     (so_o),
    .cr0_o    (cr0_o)
);

// File: tb/int_status_flags_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes expected flags from the
// requirements and queues them; the monitor compares after each update.
module int_status_flags_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd = 1'b0;
    logic        inv_a = 1'b0;
    logic [63:0] opa = '0, opb = '0, imm = '0, res = '0;
    logic        opb_vld = 1'b0, imm_vld = 1'b0, add_op = 1'b0;
    logic        ca_en = 1'b0, ca_own_vld = 1'b0, ca_own = 1'b0;
    logic        ca32_own_vld = 1'b0, ca32_own = 1'b0;
    logic        oe_en = 1'b0, oe_vld = 1'b0, div_op = 1'b0, div_ov = 1'b0;
    logic        rc = 1'b0;
    logic        ca_o, ca32_o, ov_o, ov32_o, so_o;
    logic [3:0]  cr0_o;

    int checks = 0;
    int fails  = 0;
    logic [8:0] model_q = '0;   // {ca, ca32, ov, ov32, so, cr0[3:0]}
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    int_status_flags u_int_status_flags (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .inv_a_i(inv_a),
        .opa_i(opa), .opb_i(opb), .opb_vld_i(opb_vld),
        .imm_i(imm), .imm_vld_i(imm_vld), .res_i(res), .add_op_i(add_op),
        .ca_en_i(ca_en), .ca_own_vld_i(ca_own_vld), .ca_own_i(ca_own),
        .ca32_own_vld_i(ca32_own_vld), .ca32_own_i(ca32_own),
        .oe_en_i(oe_en), .oe_vld_i(oe_vld), .div_op_i(div_op),
        .div_ov_i(div_ov), .rc_i(rc),
        .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .ov32_o(ov32_o),
        .so_o(so_o), .cr0_o(cr0_o)
    );

    function automatic logic [8:0] outs();
        return {ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o};
    endfunction

    // Reference flag model written from the requirements.
    function automatic logic [8:0] model_next(input logic [8:0] cur);
        logic [63:0] a;
        logic [63:0] s;
        logic c, c32, v, v32, so;
        logic [3:0] cr;
        a = inv_a ? ~opa : opa;                                   // R3
        s = opb_vld ? opb : (imm_vld ? imm : 64'd0);
        {c, c32, v, v32, so} = cur[8:4];
        cr = cur[3:0];
        if (ca_en) begin
            c = ca_own_vld ? ca_own :
                ((a > res) || (opb_vld && opb > res) || (imm_vld && imm > res)); // R4 R7
            if (ca32_own_vld)  c32 = ca32_own;
            else if (add_op)   c32 = res[32] ^ a[32] ^ s[32];     // R5
            else               c32 = (a[31:0] > res[31:0]) ||
                                     (opb_vld && opb[31:0] > res[31:0]) ||
                                     (imm_vld && imm[31:0] > res[31:0]); // R6
        end
        if (oe_en && oe_vld && (div_op || opb_vld || imm_vld)) begin  // R8
            if (div_op) begin v = div_ov; v32 = div_ov; end          // R9
            else begin
                v   = (a[63] == s[63]) && (res[63] != a[63]);
                v32 = (a[31] == s[31]) && (res[31] != a[31]);
            end
            so = so | v;                                              // R10
        end
        if (rc) cr = {$signed(res) < 0, $signed(res) > 0, res == 64'd0, so}; // R11
        return {c, c32, v, v32, so, cr};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Driver: queue expectation, pulse the strobe for one cycle (R12).
    task automatic strobe(input string req);
        logic [8:0] e;
        e = model_next(model_q);
        exp_q.push_back(e);
        tag_q.push_back(req);
        model_q = e;
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    // Stimulus without strobe, then confirm nothing moved (R2).
    task automatic idle_check();
        inv_a = 1'b1; opa = 64'h1234; opb = 64'hFFFF_0000_0000_0001; opb_vld = 1'b1;
        res = 64'h8000_0000_0000_0000; ca_en = 1'b1; oe_en = 1'b1; oe_vld = 1'b1;
        rc = 1'b1; div_op = 1'b1; div_ov = 1'b1;
        @(posedge clk); #1;
        check("R2", outs(), model_q);
        @(negedge clk);
    endtask

    task automatic clr();
        inv_a = 0; opa = 0; opb = 0; imm = 0; res = 0; opb_vld = 0; imm_vld = 0;
        add_op = 0; ca_en = 0; ca_own_vld = 0; ca_own = 0; ca32_own_vld = 0;
        ca32_own = 0; oe_en = 0; oe_vld = 0; div_op = 0; div_ov = 0; rc = 0;
    endtask

    // Monitor: pop and compare right after each updating edge.
    always @(posedge clk) begin
        if (rst_n && upd) begin
            #1;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), outs(), exp_q.pop_front());
            end else begin
                check("R12", 9'h1FF, 9'h000);
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", outs(), 9'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5: add carry out of both widths
        clr(); opa = '1; opb = 64'd1; opb_vld = 1; res = 64'd0; add_op = 1; ca_en = 1;
        strobe("R4 R5 add carry");
        check("R4", {ca_o, ca32_o}, 2'b11);
        // R3: inversion of zero A gives all ones
        clr(); inv_a = 1; opa = 64'd0; opb = 64'd5; opb_vld = 1; res = 64'd4; ca_en = 1;
        strobe("R3 inverted A");
        // R6: non-add half carry only
        clr(); opa = 64'h0000_0000_FFFF_FFFF; opb = 64'h0000_0002_0000_0000; opb_vld = 1;
        res = 64'h0000_0002_0000_0001; ca_en = 1;
        strobe("R6 half carry");
        check("R6", {ca_o, ca32_o}, 2'b01);
        // R4: immediate as extra operand
        clr(); opa = 64'd1; imm = 64'd100; imm_vld = 1; res = 64'd50; ca_en = 1;
        strobe("R4 immediate");
        // R7: supplied carries win
        clr(); opa = '1; res = 64'd0; ca_en = 1; ca_own_vld = 1; ca_own = 0;
        ca32_own_vld = 1; ca32_own = 0;
        strobe("R7 own carry");
        check("R7", {ca_o, ca32_o}, 2'b00);
        // R4: carry disabled keeps values
        clr(); opa = '1; res = 64'd0;
        strobe("R4 carry disabled");
        // R8: enable without valid does not write
        clr(); opa = 64'h7FFF_FFFF_FFFF_FFFF; opb = 64'd1; opb_vld = 1;
        res = 64'h8000_0000_0000_0000; oe_en = 1;
        strobe("R8 oe not valid");
        // R8 R10 R11: overflow and record in one update, SO seen in cr0
        oe_vld = 1; rc = 1;
        strobe("R8 R10 R11 ov+rc");
        check("R11", cr0_o, 4'b1001);
        check("R8", {ov_o, ov32_o, so_o}, 3'b101);
        // R10: no overflow, SO holds
        clr(); opa = 64'd1; opb = 64'd1; opb_vld = 1; res = 64'd2; oe_en = 1; oe_vld = 1; rc = 1;
        strobe("R10 sticky");
        check("R10", {ov_o, so_o, cr0_o}, 6'b010101);
        // R8: single operand, no divide, no overflow write
        clr(); opa = 64'h7FFF_FFFF_FFFF_FFFF; res = 64'h8000_0000_8000_0000; oe_en = 1; oe_vld = 1;
        strobe("R8 single operand");
        // R9: divide overflow
        clr(); div_op = 1; div_ov = 1; oe_en = 1; oe_vld = 1; rc = 1;
        strobe("R9 divide ovf");
        // R11: zero and positive results
        clr(); rc = 1; res = 64'd7;
        strobe("R11 positive");
        clr(); rc = 1; res = 64'd0;
        strobe("R11 zero");
        check("R11", cr0_o, 4'b0011);
        // R11: rc low keeps cr0
        clr(); res = 64'hF000_0000_0000_0000;
        strobe("R11 no record");
        idle_check();
        clr();
        // R3 R8: inverted A in overflow
        inv_a = 1; opa = 64'h8000_0000_8000_0000; opb = 64'h7000_0000_7000_0000; opb_vld = 1;
        res = 64'h8000_0000_8000_0000; oe_en = 1; oe_vld = 1; ca_en = 1; add_op = 1;
        strobe("R3 R8 inverted ovf");

        // Mixed random stream, reset partway to restart SO (R1).
        for (int i = 0; i < 300; i++) begin
            opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
            imm = {$urandom, $urandom}; res = {$urandom, $urandom};
            if (i % 4 == 0) res = opa + opb;
            if (i % 7 == 0) res = 64'd0;
            {inv_a, opb_vld, imm_vld, add_op, ca_en, ca_own_vld, ca_own} = 7'($urandom);
            {ca32_own_vld, ca32_own, oe_en, oe_vld, div_op, div_ov, rc} = 7'($urandom);
            if (i == 150) begin
                rst_n = 1'b0;
                @(posedge clk); #1;
                check("R1 mid reset", outs(), 9'd0);
                model_q = '0;
                @(negedge clk);
                rst_n = 1'b1;
            end
            if ($urandom % 5 == 0) idle_check();
            else strobe("R12 random");
        end
        @(negedge clk);
        if (exp_q.size() != 0) check("R12 drained", 9'(exp_q.size()), 9'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule